// File: doc/BRIEF.md
# I2C Controller Status Flag Bank

This block keeps the status flags of an I2C controller and clears them the way a memory-mapped peripheral does. The flags are set by one-cycle pulses from a protocol engine. Software clears them through ordinary register traffic. The block presents two 16-bit status words, A and B. It also raises an event interrupt and an error interrupt, each gated by group enables.

There are two clearing schemes. The five protocol-progress flags clear in two steps. A read of status word A arms every such flag that is set at that moment. A later access of the kind tied to that flag then clears it. That access can be a data-register write, a data-register read, a status-word-B read or a control write. The seven error flags clear when software writes a zero into their bit of status word A.

Each progress flag is a three-state machine with these states:
- FS_CLEAR: the flag is low.
- FS_SET: the flag is set but not armed.
- FS_ARMED: the flag is set and a status-A read has been seen.

The transitions are:
- CLEAR→SET on a set pulse.
- SET→ARMED on a status-A read.
- ARMED→CLEAR on the matching access.
- ARMED→SET on a new set pulse.

Every other case holds the current state.

Top module: `i2c_flag_bank`

## Requirements
- R1: After reset, status words A and B read 0 (with the PEC input at 0), every flag is clear and both interrupts are low.
- R2: A set pulse makes its flag read 1 from the next cycle. Status A bit 0 is start-sent, bit 1 is address-done, bit 2 is byte-finished, bit 3 is 10-bit-header-sent and bit 4 is stop-seen. Bit 6 mirrors the rx_full level and bit 7 mirrors the tx_empty level.
- R3: Start-sent (bit 0) and 10-bit-header (bit 3) each clear after a status-A read followed later by a data write.
- R4: Address-done (bit 1) clears after a status-A read followed by a status-B read. A data write does not clear it.
- R5: Byte-finished (bit 2) clears after a status-A read followed by either a data read or a data write.
- R6: Stop-seen (bit 4) clears after a status-A read followed by a control write.
- R7: The second access has no effect unless a status-A read came after the flag was set. A flag set in the same cycle as a status-A read is not armed.
- R8: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R9: The error flags sit in status A at these bits: ev_err[0] bus error at bit 8, [1] arbitration lost at bit 9, [2] acknowledge failure at bit 10, [3] overrun at bit 11, [4] PEC error at bit 12, [5] timeout at bit 14, [6] SMBus alert at bit 15. A write to status A clears the error bits written as 0 and leaves the bits written as 1 unchanged.
- R10: Status B bits 15:8 equal pec_byte. Bits 7:0 read 0.
- R11: err_irq is high when irq_en[0] is set and any error flag is set.
- R12: evt_irq is high when irq_en[1] is set and any progress flag is set. It is also high when irq_en[1] and irq_en[2] are both set and tx_empty or rx_full is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_sent | input | 1 | Set pulse, start sent |
| ev_addr_done | input | 1 | Set pulse, address phase done |
| ev_byte_done | input | 1 | Set pulse, byte finished |
| ev_stop_seen | input | 1 | Set pulse, stop detected |
| ev_hdr10_sent | input | 1 | Set pulse, 10-bit header sent |
| ev_err | input | 7 | Error set pulses (bit order in R9) |
| tx_empty | input | 1 | Transmit holding empty level |
| rx_full | input | 1 | Receive holding full level |
| stat_a_rd | input | 1 | Status word A read strobe |
| stat_a_wr | input | 1 | Status word A write strobe |
| stat_a_wdata | input | 16 | Status word A write data |
| stat_b_rd | input | 1 | Status word B read strobe |
| dat_rd | input | 1 | Data register read strobe |
| dat_wr | input | 1 | Data register write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| irq_en | input | 3 | Group enables: [0] error, [1] event, [2] buffer |
| pec_byte | input | 8 | Current packet error check byte |
| stat_a_val | output | 16 | Status word A read value |
| stat_b_val | output | 16 | Status word B read value |
| evt_irq | output | 1 | Event interrupt |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default parameters. With these values, all five progress flags, both buffer levels and all seven error flags share one 16-bit status word. Comparing the whole word against the reference model each cycle therefore covers every flag at once.

Directed sequences reach the cases where ordering matters:
- A second access with no status-A read before it.
- A set pulse landing in the same cycle as the arming read.
- A set pulse landing in the same cycle as the clearing access.
- Error writes that mix zeros and ones.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

    typedef enum logic [1:0] {
        FS_CLEAR = 2'd0,
        FS_SET   = 2'd1,
        FS_ARMED = 2'd2
    } flag_st_t;

    // access vector bit order: [0] status-B read, [1] data read, [2] data write, [3] control write
    localparam int ACC_W = 4;

    // which second access clears progress flag idx (idx = status-A bit)
    function automatic logic [ACC_W-1:0] clr_mask(input int idx);
        case (idx)
            0:       return 4'b0100;   // start sent: data write
            1:       return 4'b0001;   // address done: status-B read
            2:       return 4'b0110;   // byte finished: data read or write
            3:       return 4'b0100;   // 10-bit header: data write
            default: return 4'b1000;   // stop seen: control write
        endcase
    endfunction

    // status-A bit position of error flag idx
    function automatic int err_pos(input int idx);
        return (idx < 5) ? (8 + idx) : (9 + idx);
    endfunction

endpackage

// File: rtl/seq_flag_cell.sv
module seq_flag_cell
    import i2c_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic arm_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_st_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAR: if (set_i) state_d = FS_SET;
            FS_SET:   if (!set_i && arm_i) state_d = FS_ARMED;
            FS_ARMED: begin
                if (set_i)      state_d = FS_SET;
                else if (clr_i) state_d = FS_CLEAR;
            end
            default:  state_d = FS_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q != FS_CLEAR);
    end

endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int NUM_ERR = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] set_i,
    input  logic               wr_i,
    input  logic [NUM_ERR-1:0] keep_i,
    output logic [NUM_ERR-1:0] flags_o
);

    logic [NUM_ERR-1:0] flags_q, flags_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    always_comb begin
        flags_d = flags_q;
        if (wr_i) flags_d = flags_q & keep_i;
        flags_d = flags_d | set_i;   // set wins over a same-cycle zero write
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner (
    input  logic       seq_any_i,
    input  logic       buf_any_i,
    input  logic       err_any_i,
    input  logic [2:0] en_i,
    output logic       evt_irq_o,
    output logic       err_irq_o
);

    always_comb begin
        err_irq_o = en_i[0] & err_any_i;
        evt_irq_o = en_i[1] & (seq_any_i | (en_i[2] & buf_any_i));
    end

endmodule

// File: rtl/i2c_flag_bank.sv
module i2c_flag_bank
    import i2c_flag_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int PEC_W   = 8,
    parameter int NUM_SEQ = 5,
    parameter int NUM_ERR = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_start_sent,
    input  logic               ev_addr_done,
    input  logic               ev_byte_done,
    input  logic               ev_stop_seen,
    input  logic               ev_hdr10_sent,
    input  logic [NUM_ERR-1:0] ev_err,
    input  logic               tx_empty,
    input  logic               rx_full,
    input  logic               stat_a_rd,
    input  logic               stat_a_wr,
    input  logic [STAT_W-1:0]  stat_a_wdata,
    input  logic               stat_b_rd,
    input  logic               dat_rd,
    input  logic               dat_wr,
    input  logic               ctrl_wr,
    input  logic [2:0]         irq_en,
    input  logic [PEC_W-1:0]   pec_byte,
    output logic [STAT_W-1:0]  stat_a_val,
    output logic [STAT_W-1:0]  stat_b_val,
    output logic               evt_irq,
    output logic               err_irq
);

    localparam int LOW_W = STAT_W - PEC_W;

    logic [NUM_SEQ-1:0] seq_set, seq_flag;
    logic [ACC_W-1:0]   acc;
    logic [NUM_ERR-1:0] err_keep, err_flag;
    logic [STAT_W-1:0]  err_word;

    assign seq_set = {ev_stop_seen, ev_hdr10_sent, ev_byte_done, ev_addr_done, ev_start_sent};
    assign acc     = {ctrl_wr, dat_wr, dat_rd, stat_b_rd};

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        localparam logic [ACC_W-1:0] MASK = clr_mask(g);
        seq_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (seq_set[g]),
            .arm_i (stat_a_rd),
            .clr_i (|(acc & MASK)),
            .flag_o(seq_flag[g])
        );
    end

    for (genvar e = 0; e < NUM_ERR; e++) begin : g_keep
        assign err_keep[e] = stat_a_wdata[err_pos(e)];
    end

    logic unused_wdata;
    assign unused_wdata = ^{stat_a_wdata[7:0], stat_a_wdata[13]};

    err_flag_bank #(.NUM_ERR(NUM_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_err),
        .wr_i   (stat_a_wr),
        .keep_i (err_keep),
        .flags_o(err_flag)
    );

    always_comb begin
        err_word = '0;
        for (int e = 0; e < NUM_ERR; e++) err_word[err_pos(e)] = err_flag[e];
    end

    always_comb begin
        stat_a_val = err_word;
        stat_a_val[NUM_SEQ-1:0] = seq_flag;
        stat_a_val[6] = rx_full;
        stat_a_val[7] = tx_empty;
        stat_b_val = {pec_byte, {LOW_W{1'b0}}};
    end

    irq_combiner u_irq (
        .seq_any_i(|seq_flag),
        .buf_any_i(tx_empty | rx_full),
        .err_any_i(|err_flag),
        .en_i     (irq_en),
        .evt_irq_o(evt_irq),
        .err_irq_o(err_irq)
    );

endmodule

// File: rtl/i2c_flag_bank_chk.sv
module i2c_flag_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_start_sent,
    input logic [6:0]  ev_err,
    input logic        stat_a_wr,
    input logic [15:0] stat_a_wdata,
    input logic        stat_b_rd,
    input logic        dat_wr,
    input logic        ctrl_wr,
    input logic [2:0]  irq_en,
    input logic [15:0] stat_a_val,
    input logic        evt_irq,
    input logic        err_irq
);

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_sent |=> stat_a_val[0]);                                          // R8
    AST_START_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_a_val[0]) |-> $past(dat_wr));                                   // R3
    AST_ADDR_CLR_BY_B_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_a_val[1]) |-> $past(stat_b_rd));                                // R4
    AST_STOP_CLR_BY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_a_val[4]) |-> $past(ctrl_wr));                                  // R6
    AST_ERR_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a_wr && stat_a_wdata[8] && stat_a_val[8]) |=> stat_a_val[8]);        // R9
    AST_ERR_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a_wr && !stat_a_wdata[15] && !ev_err[6]) |=> !stat_a_val[15]);       // R9
    AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en[0] |-> !err_irq);                                                  // R11
    AST_EVT_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en[1] |-> !evt_irq);                                                  // R12

endmodule

bind i2c_flag_bank i2c_flag_bank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start_sent(ev_start_sent),
    .ev_err       (ev_err),
    .stat_a_wr    (stat_a_wr),
    .stat_a_wdata (stat_a_wdata),
    .stat_b_rd    (stat_b_rd),
    .dat_wr       (dat_wr),
    .ctrl_wr      (ctrl_wr),
    .irq_en       (irq_en),
    .stat_a_val   (stat_a_val),
    .evt_irq      (evt_irq),
    .err_irq      (err_irq)
);

// File: tb/i2c_flag_bank_tb_top.sv
module i2c_flag_bank_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start_sent = 0, ev_addr_done = 0, ev_byte_done = 0, ev_stop_seen = 0, ev_hdr10_sent = 0;
    logic [6:0]  ev_err = '0;
    logic tx_empty = 0, rx_full = 0;
    logic stat_a_rd = 0, stat_a_wr = 0, stat_b_rd = 0, dat_rd = 0, dat_wr = 0, ctrl_wr = 0;
    logic [15:0] stat_a_wdata = '0;
    logic [2:0]  irq_en = '0;
    logic [7:0]  pec_byte = '0;
    logic [15:0] stat_a_val, stat_b_val;
    logic evt_irq, err_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    i2c_flag_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_start_sent(ev_start_sent), .ev_addr_done(ev_addr_done), .ev_byte_done(ev_byte_done),
        .ev_stop_seen(ev_stop_seen), .ev_hdr10_sent(ev_hdr10_sent), .ev_err(ev_err),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .stat_a_rd(stat_a_rd), .stat_a_wr(stat_a_wr), .stat_a_wdata(stat_a_wdata),
        .stat_b_rd(stat_b_rd), .dat_rd(dat_rd), .dat_wr(dat_wr), .ctrl_wr(ctrl_wr),
        .irq_en(irq_en), .pec_byte(pec_byte),
        .stat_a_val(stat_a_val), .stat_b_val(stat_b_val), .evt_irq(evt_irq), .err_irq(err_irq)
    );

    // behavioural reference model
    bit m_f[5];
    bit m_arm[5];
    bit [15:0] m_e;

    function automatic bit clr_hit(int b);
        case (b)
            0, 3: return dat_wr;
            1:    return stat_b_rd;
            2:    return dat_rd || dat_wr;
            default: return ctrl_wr;
        endcase
    endfunction

    always @(posedge clk) begin
        bit setv[5];
        bit hit[5];
        bit [15:0] eset;
        if (!rst_n) begin
            foreach (m_f[i]) begin m_f[i] = 0; m_arm[i] = 0; end
            m_e = '0;
        end else begin
            setv = '{ev_start_sent, ev_addr_done, ev_byte_done, ev_hdr10_sent, ev_stop_seen};
            foreach (hit[i]) hit[i] = clr_hit(i);
            for (int b = 0; b < 5; b++) begin
                if (setv[b]) begin m_f[b] = 1; m_arm[b] = 0; end
                else if (m_arm[b] && hit[b]) begin m_f[b] = 0; m_arm[b] = 0; end
                else if (stat_a_rd && m_f[b]) m_arm[b] = 1;
            end
            eset = {ev_err[6:5], 1'b0, ev_err[4:0], 8'h00};
            if (stat_a_wr) m_e = m_e & stat_a_wdata & 16'hDF00;
            m_e = m_e | eset;
        end
    end

    function automatic string tag_of(int b);
        case (b)
            0, 3: return "R3";
            1:    return "R4";
            2:    return "R5";
            4:    return "R6";
            6, 7: return "R2";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        logic [15:0] ea;
        bit anyf;
        if (rst_n && !done) begin
            ea = m_e;
            ea[0] = m_f[0]; ea[1] = m_f[1]; ea[2] = m_f[2]; ea[3] = m_f[3]; ea[4] = m_f[4];
            ea[6] = rx_full; ea[7] = tx_empty;
            anyf = m_f[0] | m_f[1] | m_f[2] | m_f[3] | m_f[4];
            for (int b = 0; b < 16; b++)
                if (stat_a_val[b] !== ea[b]) chk(tag_of(b), {15'd0, stat_a_val[b]}, {15'd0, ea[b]});
            total++;
            chk("R10", stat_b_val, {pec_byte, 8'h00});
            chk("R11", {15'd0, err_irq}, {15'd0, irq_en[0] & (|m_e)});
            chk("R12", {15'd0, evt_irq},
                {15'd0, irq_en[1] & (anyf | (irq_en[2] & (tx_empty | rx_full)))});
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        ev_start_sent = 0; ev_addr_done = 0; ev_byte_done = 0; ev_stop_seen = 0; ev_hdr10_sent = 0;
        ev_err = '0; stat_a_rd = 0; stat_a_wr = 0; stat_b_rd = 0; dat_rd = 0; dat_wr = 0; ctrl_wr = 0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1", stat_a_val, 16'h0000);
        chk("R1", stat_b_val, 16'h0000);
        chk("R1", {14'd0, evt_irq, err_irq}, 16'h0);

        pec_byte = 8'hA5; #1;
        chk("R10", stat_b_val, 16'hA500);

        // R2 set, R7 no clear without the arming read
        irq_en = 3'b010;
        ev_start_sent = 1; step();
        chk("R2", stat_a_val, 16'h0001);
        chk("R12", {15'd0, evt_irq}, 16'h1);
        dat_wr = 1; step();
        chk("R7", stat_a_val, 16'h0001);
        stat_a_rd = 1; step();
        dat_wr = 1; step();
        chk("R3", stat_a_val, 16'h0000);

        // R3 10-bit header
        ev_hdr10_sent = 1; step();
        stat_a_rd = 1; step();
        dat_wr = 1; step();
        chk("R3", stat_a_val, 16'h0000);

        // R4 address: data write does not clear, status-B read does
        ev_addr_done = 1; step();
        stat_a_rd = 1; step();
        dat_wr = 1; step();
        chk("R4", stat_a_val, 16'h0002);
        stat_b_rd = 1; step();
        chk("R4", stat_a_val, 16'h0000);

        // R5 byte finished via read, then via write
        ev_byte_done = 1; step();
        stat_a_rd = 1; step();
        dat_rd = 1; step();
        chk("R5", stat_a_val, 16'h0000);
        ev_byte_done = 1; step();
        stat_a_rd = 1; step();
        dat_wr = 1; step();
        chk("R5", stat_a_val, 16'h0000);

        // R6 stop, R7 same-cycle set and read, R8 set beats clear
        ev_stop_seen = 1; step();
        stat_a_rd = 1; step();
        ctrl_wr = 1; step();
        chk("R6", stat_a_val, 16'h0000);
        ev_stop_seen = 1; stat_a_rd = 1; step();
        ctrl_wr = 1; step();
        chk("R7", stat_a_val, 16'h0010);
        stat_a_rd = 1; step();
        ctrl_wr = 1; ev_stop_seen = 1; step();
        chk("R8", stat_a_val, 16'h0010);
        stat_a_rd = 1; step();
        ctrl_wr = 1; step();
        chk("R6", stat_a_val, 16'h0000);

        // R9 error flags, R11 gating
        irq_en = 3'b000;
        ev_err = 7'h7F; step();
        chk("R9", stat_a_val, 16'hDF00);
        chk("R11", {15'd0, err_irq}, 16'h0);
        irq_en = 3'b001; #1;
        chk("R11", {15'd0, err_irq}, 16'h1);
        stat_a_wr = 1; stat_a_wdata = 16'hFFFF; step();
        chk("R9", stat_a_val, 16'hDF00);
        stat_a_wr = 1; stat_a_wdata = 16'hFEFF; step();
        chk("R9", stat_a_val, 16'hDE00);
        stat_a_wr = 1; stat_a_wdata = 16'h0000; ev_err = 7'h02; step();
        chk("R8", stat_a_val, 16'h0200);
        stat_a_wr = 1; stat_a_wdata = 16'h0000; step();
        chk("R9", stat_a_val, 16'h0000);
        chk("R11", {15'd0, err_irq}, 16'h0);

        // R12 buffer group, R2 level mirroring
        tx_empty = 1; irq_en = 3'b010; step();
        chk("R2", stat_a_val, 16'h0080);
        chk("R12", {15'd0, evt_irq}, 16'h0);
        irq_en = 3'b110; #1;
        chk("R12", {15'd0, evt_irq}, 16'h1);
        tx_empty = 0; rx_full = 1; irq_en = 3'b100; step();
        chk("R12", {15'd0, evt_irq}, 16'h0);
        chk("R2", stat_a_val, 16'h0040);
        rx_full = 0; step();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule